// File: doc/BRIEF.md
# Completion and Event Queue Doorbell Processor

This block takes 32-bit doorbell words that software writes to return consumed entries to a completion queue (CQ) or an event queue (EQ). It checks each word's format first. A well-formed word moves the selected queue's consumer index forward by the number of popped entries, wrapping modulo the queue depth. It can also arm that queue for notification. A word with any reserved bit set, or with a queue number beyond the configured count, is not executed. Instead the block raises a one-cycle bad-queue-ID error that carries the offending queue number.

Each queue also holds a producer index, written by the entry-producing side through a separate port. A queue counts as pending while its producer and consumer indices differ. A notify scanner built as a two-state machine walks every queue in turn. In `ST_SCAN` it looks at the queue under its pointer. It moves to `ST_FIRE` when that queue is armed and pending, and otherwise it advances the pointer. In `ST_FIRE` it emits a one-cycle notify pulse if the queue is still armed and pending, clears the armed flag, advances the pointer and returns to `ST_SCAN`. A combinational read port gives the consumer index and armed flag of any queue, so the producer side can compute free space.

Queue depth must be a power of two. The consumer and producer indices are `log2(QDEPTH)` bits wide.

Top module: `cqdb_proc`

## Requirements
- R1: Doorbell word layout: queue number in bits [9:0], rearm in bit 14, queue-type select in bit 15, popped count in bits [28:16]; bits [13:10] and [31:29] are reserved.
- R2: A well-formed doorbell adds its popped count, modulo QDEPTH, to the selected queue's consumer index at the accepting clock edge; the read port shows the new value in the following cycle.
- R3: Type bit 1 selects the event queue table and 0 the completion queue table; the same queue number in the other table is not affected.
- R4: A doorbell with any reserved bit set changes no queue state, and one cycle after the accepting edge err_valid pulses for one cycle with err_qid equal to bits [9:0] of the word.
- R5: A doorbell whose queue number is not below the selected table's count (NUM_CQ or NUM_EQ) is treated exactly as in R4.
- R6: A well-formed doorbell with rearm 1 sets the queue's armed flag; with rearm 0 it leaves the flag unchanged.
- R7: notify_valid is high only in a cycle where the named queue is armed and its producer index differs from its consumer index; it never stays high on two consecutive cycles, and the queue's armed flag is clear afterwards.
- R8: A queue that stays armed and pending is notified within 2*(NUM_CQ+NUM_EQ) cycles.
- R9: After reset every consumer index is zero, every armed flag is clear, and neither notify_valid nor err_valid is high.
- R10: A producer-index write to an in-range queue replaces that queue's producer index; an out-of-range write is ignored.
- R11: When a rearm doorbell and a notify clear hit the same queue at the same edge, the armed flag ends set.
- R12: The read port returns zero index and clear armed flag for a queue number outside the selected table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell word present this cycle |
| db_word | input | 32 | Doorbell word |
| pi_valid | input | 1 | Producer index write strobe |
| pi_is_eq | input | 1 | Producer write targets the event queue table |
| pi_qid | input | 10 | Producer write queue number |
| pi_index | input | log2(QDEPTH) | New producer index |
| rd_is_eq | input | 1 | Read port table select |
| rd_qid | input | 10 | Read port queue number |
| rd_cidx | output | log2(QDEPTH) | Consumer index of the read queue |
| rd_armed | output | 1 | Armed flag of the read queue |
| notify_valid | output | 1 | One-cycle notification pulse |
| notify_is_eq | output | 1 | Notified queue is an event queue |
| notify_qid | output | 10 | Notified queue number |
| err_valid | output | 1 | One-cycle bad-queue-ID error |
| err_qid | output | 10 | Queue number field of the rejected doorbell |

## Verification
If a consumer index is corrupted, the read port shows it on the very next cycle after the doorbell edge. Because of that, the model compares the read port every cycle against a queue whose number is picked at random. If an armed flag is lost or stuck, the error shows in one of two ways. Either a notify pulse names a queue that the model holds disarmed or not pending. Or an armed, pending queue is still unserved after a full scanner lap, which the quiet tail of the run exposes within 2*(NUM_CQ+NUM_EQ) cycles. If a rejected word leaks into state, it appears as an index step at the read port, together with a missing or wrong err_qid one cycle later.

// File: rtl/cqdb_pkg.sv
package cqdb_pkg;

    // Doorbell word field geometry (fixed by the word format)
    localparam int QID_W     = 10;
    localparam int POP_W     = 13;
    localparam int QID_LSB   = 0;
    localparam int RSVL_LSB  = 10;
    localparam int RSVL_W    = 4;
    localparam int REARM_BIT = 14;
    localparam int TYPE_BIT  = 15;
    localparam int POP_LSB   = 16;
    localparam int RSVH_LSB  = 29;
    localparam int RSVH_W    = 3;

    typedef struct packed {
        logic [QID_W-1:0] qid;
        logic             rearm;
        logic             is_eq;
        logic [POP_W-1:0] pop;
    } db_fields_t;

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_FIRE = 1'b1
    } scan_state_e;

endpackage

// File: rtl/cqdb_decode.sv
module cqdb_decode
    import cqdb_pkg::*;
#(
    parameter int NUM_CQ = 16,
    parameter int NUM_EQ = 8
) (
    input  logic [31:0] word,
    output db_fields_t  fields,
    output logic        ok,
    output logic        bad
);

    logic rsv_nz;
    logic qid_oor;
    logic [QID_W:0] limit;

    always_comb begin
        fields.qid   = word[QID_LSB +: QID_W];
        fields.rearm = word[REARM_BIT];
        fields.is_eq = word[TYPE_BIT];
        fields.pop   = word[POP_LSB +: POP_W];
    end

    always_comb begin
        rsv_nz  = (|word[RSVL_LSB +: RSVL_W]) | (|word[RSVH_LSB +: RSVH_W]);
        limit   = fields.is_eq ? (QID_W+1)'(NUM_EQ) : (QID_W+1)'(NUM_CQ);
        qid_oor = ({1'b0, fields.qid} >= limit);
        bad     = rsv_nz | qid_oor;
        ok      = ~bad;
    end

endmodule

// File: rtl/cqdb_qtable.sv
module cqdb_qtable
    import cqdb_pkg::*;
#(
    parameter int NQ     = 16,
    parameter int CIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [QID_W-1:0]  upd_qid,
    input  logic [POP_W-1:0]  upd_pop,
    input  logic              upd_rearm,
    input  logic              pi_en,
    input  logic [QID_W-1:0]  pi_qid,
    input  logic [CIDX_W-1:0] pi_val,
    input  logic              clr_en,
    input  logic [QID_W-1:0]  clr_qid,
    input  logic [QID_W-1:0]  rd_qid,
    output logic [CIDX_W-1:0] rd_cidx,
    output logic              rd_armed,
    input  logic [QID_W-1:0]  scan_qid,
    output logic              scan_ready
);

    logic [CIDX_W-1:0] cidx_q  [NQ];
    logic [CIDX_W-1:0] pidx_q  [NQ];
    logic              armed_q [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_entry
        logic hit_upd;
        logic hit_pi;
        logic hit_clr;

        assign hit_upd = upd_en && (upd_qid == QID_W'(g));
        assign hit_pi  = pi_en  && (pi_qid  == QID_W'(g));
        assign hit_clr = clr_en && (clr_qid == QID_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cidx_q[g]  <= '0;
                pidx_q[g]  <= '0;
                armed_q[g] <= 1'b0;
            end else begin
                if (hit_upd) begin
                    cidx_q[g] <= cidx_q[g] + CIDX_W'(upd_pop);
                end
                if (hit_pi) begin
                    pidx_q[g] <= pi_val;
                end
                // a rearm at the same edge as a clear wins
                if (hit_upd && upd_rearm) begin
                    armed_q[g] <= 1'b1;
                end else if (hit_clr) begin
                    armed_q[g] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        rd_cidx    = '0;
        rd_armed   = 1'b0;
        scan_ready = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (rd_qid == QID_W'(i)) begin
                rd_cidx  = cidx_q[i];
                rd_armed = armed_q[i];
            end
            if (scan_qid == QID_W'(i)) begin
                scan_ready = armed_q[i] && (pidx_q[i] != cidx_q[i]);
            end
        end
    end

endmodule

// File: rtl/cqdb_notify.sv
module cqdb_notify
    import cqdb_pkg::*;
#(
    parameter int NUM_CQ = 16,
    parameter int NUM_EQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cq_ready,
    input  logic             eq_ready,
    output logic [QID_W-1:0] scan_qid,
    output logic             scan_is_eq,
    output logic             notify_valid,
    output logic             notify_is_eq,
    output logic [QID_W-1:0] notify_qid
);

    localparam int TOTAL = NUM_CQ + NUM_EQ;
    localparam int PTR_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

    scan_state_e      state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [PTR_W-1:0] ptr_inc;
    logic             ready;

    always_comb begin
        ptr_inc = (ptr_q == PTR_W'(TOTAL - 1)) ? '0 : ptr_q + 1'b1;
        if (ptr_q < PTR_W'(NUM_CQ)) begin
            scan_is_eq = 1'b0;
            scan_qid   = QID_W'(ptr_q);
        end else begin
            scan_is_eq = 1'b1;
            scan_qid   = QID_W'(ptr_q - PTR_W'(NUM_CQ));
        end
        ready = scan_is_eq ? eq_ready : cq_ready;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_SCAN: begin
                if (ready) begin
                    state_d = ST_FIRE;
                end else begin
                    ptr_d = ptr_inc;
                end
            end
            ST_FIRE: begin
                state_d = ST_SCAN;
                ptr_d   = ptr_inc;
            end
            default: begin
                state_d = ST_SCAN;
                ptr_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        notify_valid = 1'b0;
        unique case (state_q)
            ST_SCAN: notify_valid = 1'b0;
            ST_FIRE: notify_valid = ready;
            default: notify_valid = 1'b0;
        endcase
        notify_is_eq = scan_is_eq;
        notify_qid   = scan_qid;
    end

endmodule

// File: rtl/cqdb_proc.sv
module cqdb_proc
    import cqdb_pkg::*;
#(
    parameter  int NUM_CQ = 16,
    parameter  int NUM_EQ = 8,
    parameter  int QDEPTH = 256,
    localparam int CIDX_W = $clog2(QDEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              db_valid,
    input  logic [31:0]       db_word,
    input  logic              pi_valid,
    input  logic              pi_is_eq,
    input  logic [QID_W-1:0]  pi_qid,
    input  logic [CIDX_W-1:0] pi_index,
    input  logic              rd_is_eq,
    input  logic [QID_W-1:0]  rd_qid,
    output logic [CIDX_W-1:0] rd_cidx,
    output logic              rd_armed,
    output logic              notify_valid,
    output logic              notify_is_eq,
    output logic [QID_W-1:0]  notify_qid,
    output logic              err_valid,
    output logic [QID_W-1:0]  err_qid
);

    db_fields_t        dec;
    logic              dec_ok;
    logic              dec_bad;
    logic              cq_upd, eq_upd;
    logic              cq_pi, eq_pi;
    logic              cq_clr, eq_clr;
    logic [CIDX_W-1:0] cq_rd_cidx, eq_rd_cidx;
    logic              cq_rd_armed, eq_rd_armed;
    logic              cq_ready, eq_ready;
    logic [QID_W-1:0]  scan_qid;
    logic              scan_is_eq;

    cqdb_decode #(.NUM_CQ(NUM_CQ), .NUM_EQ(NUM_EQ)) u_decode (
        .word   (db_word),
        .fields (dec),
        .ok     (dec_ok),
        .bad    (dec_bad)
    );

    assign cq_upd = db_valid && dec_ok && !dec.is_eq;
    assign eq_upd = db_valid && dec_ok &&  dec.is_eq;
    assign cq_pi  = pi_valid && !pi_is_eq;
    assign eq_pi  = pi_valid &&  pi_is_eq;
    assign cq_clr = notify_valid && !notify_is_eq;
    assign eq_clr = notify_valid &&  notify_is_eq;

    cqdb_qtable #(.NQ(NUM_CQ), .CIDX_W(CIDX_W)) u_cq_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (cq_upd),
        .upd_qid    (dec.qid),
        .upd_pop    (dec.pop),
        .upd_rearm  (dec.rearm),
        .pi_en      (cq_pi),
        .pi_qid     (pi_qid),
        .pi_val     (pi_index),
        .clr_en     (cq_clr),
        .clr_qid    (notify_qid),
        .rd_qid     (rd_qid),
        .rd_cidx    (cq_rd_cidx),
        .rd_armed   (cq_rd_armed),
        .scan_qid   (scan_qid),
        .scan_ready (cq_ready)
    );

    cqdb_qtable #(.NQ(NUM_EQ), .CIDX_W(CIDX_W)) u_eq_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (eq_upd),
        .upd_qid    (dec.qid),
        .upd_pop    (dec.pop),
        .upd_rearm  (dec.rearm),
        .pi_en      (eq_pi),
        .pi_qid     (pi_qid),
        .pi_val     (pi_index),
        .clr_en     (eq_clr),
        .clr_qid    (notify_qid),
        .rd_qid     (rd_qid),
        .rd_cidx    (eq_rd_cidx),
        .rd_armed   (eq_rd_armed),
        .scan_qid   (scan_qid),
        .scan_ready (eq_ready)
    );

    cqdb_notify #(.NUM_CQ(NUM_CQ), .NUM_EQ(NUM_EQ)) u_notify (
        .clk          (clk),
        .rst_n        (rst_n),
        .cq_ready     (cq_ready),
        .eq_ready     (eq_ready),
        .scan_qid     (scan_qid),
        .scan_is_eq   (scan_is_eq),
        .notify_valid (notify_valid),
        .notify_is_eq (notify_is_eq),
        .notify_qid   (notify_qid)
    );

    assign rd_cidx  = rd_is_eq ? eq_rd_cidx  : cq_rd_cidx;
    assign rd_armed = rd_is_eq ? eq_rd_armed : cq_rd_armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_qid   <= '0;
        end else begin
            err_valid <= db_valid && dec_bad;
            err_qid   <= dec.qid;
        end
    end

endmodule

// File: rtl/cqdb_chk.sv
module cqdb_chk #(
    parameter int NUM_CQ = 16,
    parameter int NUM_EQ = 8,
    parameter int CIDX_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              db_valid,
    input logic [31:0]       db_word,
    input logic              rd_is_eq,
    input logic [9:0]        rd_qid,
    input logic [CIDX_W-1:0] rd_cidx,
    input logic              rd_armed,
    input logic              notify_valid,
    input logic              err_valid,
    input logic [9:0]        err_qid
);

    logic word_ok;
    logic rd_hit;

    always_comb begin
        word_ok = (db_word[13:10] == 4'd0) && (db_word[31:29] == 3'd0) &&
                  ({1'b0, db_word[9:0]} < (db_word[15] ? 11'(NUM_EQ) : 11'(NUM_CQ)));
        rd_hit  = (db_word[15] == rd_is_eq) && (db_word[9:0] == rd_qid);
    end

    // R2
    cidx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(db_valid) && $past(word_ok) && $past(rd_hit) &&
         $stable(rd_is_eq) && $stable(rd_qid))
        |-> (rd_cidx == CIDX_W'($past(rd_cidx) + $past(db_word[28:16]))));

    // R4
    bad_db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(db_valid) && !$past(word_ok) && $stable(rd_is_eq) && $stable(rd_qid))
        |-> (rd_cidx == $past(rd_cidx)));

    // R4
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> ($past(db_valid) && !$past(word_ok) && (err_qid == $past(db_word[9:0]))));

    // R6
    rearm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(db_valid) && $past(word_ok) && $past(db_word[14]) && $past(rd_hit) &&
         $stable(rd_is_eq) && $stable(rd_qid))
        |-> rd_armed);

    // R7
    notify_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |=> !notify_valid);

endmodule

bind cqdb_proc cqdb_chk #(
    .NUM_CQ (NUM_CQ),
    .NUM_EQ (NUM_EQ),
    .CIDX_W (CIDX_W)
) u_cqdb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .db_valid     (db_valid),
    .db_word      (db_word),
    .rd_is_eq     (rd_is_eq),
    .rd_qid       (rd_qid),
    .rd_cidx      (rd_cidx),
    .rd_armed     (rd_armed),
    .notify_valid (notify_valid),
    .err_valid    (err_valid),
    .err_qid      (err_qid)
);

// File: tb/test_cqdb_proc.sv
`timescale 1ns/1ps
module test_cqdb_proc;

    localparam int NUM_CQ = 16;
    localparam int NUM_EQ = 8;
    localparam int QDEPTH = 256;
    localparam int CW     = $clog2(QDEPTH);
    localparam int TOTAL  = NUM_CQ + NUM_EQ;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          db_valid = 1'b0;
    logic [31:0]   db_word = '0;
    logic          pi_valid = 1'b0;
    logic          pi_is_eq = 1'b0;
    logic [9:0]    pi_qid = '0;
    logic [CW-1:0] pi_index = '0;
    logic          rd_is_eq = 1'b0;
    logic [9:0]    rd_qid = '0;
    logic [CW-1:0] rd_cidx;
    logic          rd_armed;
    logic          notify_valid;
    logic          notify_is_eq;
    logic [9:0]    notify_qid;
    logic          err_valid;
    logic [9:0]    err_qid;

    always #10 clk = ~clk;

    cqdb_proc #(.NUM_CQ(NUM_CQ), .NUM_EQ(NUM_EQ), .QDEPTH(QDEPTH)) i_cqdb_proc (
        .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_word(db_word),
        .pi_valid(pi_valid), .pi_is_eq(pi_is_eq), .pi_qid(pi_qid), .pi_index(pi_index),
        .rd_is_eq(rd_is_eq), .rd_qid(rd_qid), .rd_cidx(rd_cidx), .rd_armed(rd_armed),
        .notify_valid(notify_valid), .notify_is_eq(notify_is_eq), .notify_qid(notify_qid),
        .err_valid(err_valid), .err_qid(err_qid)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R9";

    int m_cidx  [2][NUM_CQ];
    int m_pidx  [2][NUM_CQ];
    bit m_armed [2][NUM_CQ];
    bit exp_err = 1'b0;
    int exp_eq  = 0;

    function automatic int qcount(input bit eq);
        return eq ? NUM_EQ : NUM_CQ;
    endfunction

    // R1: field positions of the doorbell word
    function automatic logic [31:0] mk_db(input int qid, input bit re, input bit eq,
                                          input int pop, input logic [6:0] rsv);
        logic [31:0] w;
        w        = '0;
        w[9:0]   = 10'(qid);
        w[13:10] = rsv[3:0];
        w[14]    = re;
        w[15]    = eq;
        w[28:16] = 13'(pop);
        w[31:29] = rsv[6:4];
        return w;
    endfunction

    function automatic bit legal(input logic [31:0] w);
        return (w[13:10] == 0) && (w[31:29] == 0) && (int'(w[9:0]) < qcount(w[15]));
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit dv, input logic [31:0] w, input bit pv, input bit pe,
                        input int pq, input int pidx, input bit re, input int rq);
        int ec;
        bit ea;
        @(negedge clk);
        // read port against model (R12 for out of range numbers)
        if (rq_in_range()) begin
            ec = m_cidx[rd_is_eq][rd_qid];
            ea = m_armed[rd_is_eq][rd_qid];
        end else begin
            ec = 0;
            ea = 1'b0;
        end
        chk(int'(rd_cidx) == ec, "consumer index (R2 R12)", int'(rd_cidx), ec);
        chk(rd_armed == ea, "armed flag (R6 R11 R12)", int'(rd_armed), int'(ea));
        chk(err_valid == exp_err, "error pulse (R4 R5)", int'(err_valid), int'(exp_err));
        if (exp_err && err_valid)
            chk(int'(err_qid) == exp_eq, "error queue number (R4)", int'(err_qid), exp_eq);
        if (notify_valid) begin
            bit okn;
            okn = (int'(notify_qid) < qcount(notify_is_eq)) &&
                  m_armed[notify_is_eq][notify_qid] &&
                  (m_pidx[notify_is_eq][notify_qid] != m_cidx[notify_is_eq][notify_qid]);
            chk(okn, "notify only armed and pending (R7)", int'(notify_qid), -1);
            if (okn) m_armed[notify_is_eq][notify_qid] = 1'b0;
        end
        // drive next stimulus and advance model
        db_valid = dv;
        db_word  = w;
        pi_valid = pv;
        pi_is_eq = pe;
        pi_qid   = 10'(pq);
        pi_index = CW'(pidx);
        rd_is_eq = re;
        rd_qid   = 10'(rq);
        exp_err  = dv && !legal(w);
        exp_eq   = int'(w[9:0]);
        if (dv && legal(w)) begin
            m_cidx[w[15]][w[9:0]] = (m_cidx[w[15]][w[9:0]] + int'(w[28:16])) % QDEPTH;
            if (w[14]) m_armed[w[15]][w[9:0]] = 1'b1;  // R11: set after clear
        end
        if (pv && pq < qcount(pe)) m_pidx[pe][pq] = pidx % QDEPTH;  // R10
    endtask

    function automatic bit rq_in_range();
        return int'(rd_qid) < qcount(rd_is_eq);
    endfunction

    task automatic idle(input bit re, input int rq);
        step(1'b0, '0, 1'b0, 1'b0, 0, 0, re, rq);
    endtask

    initial begin
        for (int t = 0; t < 2; t++)
            for (int q = 0; q < NUM_CQ; q++) begin
                m_cidx[t][q] = 0; m_pidx[t][q] = 0; m_armed[t][q] = 1'b0;
            end
        void'($urandom(32'h1d0b_7a55));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state on every queue
        tag = "R9";
        for (int q = 0; q < NUM_CQ; q++) idle(1'b0, q);
        for (int q = 0; q < NUM_EQ; q++) idle(1'b1, q);
        @(negedge clk);
        chk(!notify_valid && !err_valid, "no pulses after reset", int'(notify_valid), 0);

        // R3: same number, different tables
        tag = "R3";
        step(1'b1, mk_db(3, 0, 0, 5, 0), 0, 0, 0, 0, 1'b0, 3);
        step(1'b1, mk_db(3, 0, 1, 9, 0), 0, 0, 0, 0, 1'b1, 3);
        idle(1'b0, 3);
        idle(1'b1, 3);

        // R2: wrap modulo depth, largest count
        tag = "R2";
        step(1'b1, mk_db(5, 0, 0, QDEPTH + 3, 0), 0, 0, 0, 0, 1'b0, 5);
        step(1'b1, mk_db(5, 0, 0, 8191, 0), 0, 0, 0, 0, 1'b0, 5);
        idle(1'b0, 5);

        // R4: reserved bits, low and high group
        tag = "R4";
        step(1'b1, mk_db(6, 1, 0, 7, 7'b0000100), 0, 0, 0, 0, 1'b0, 6);
        step(1'b1, mk_db(6, 1, 0, 7, 7'b0100000), 0, 0, 0, 0, 1'b0, 6);
        idle(1'b0, 6);

        // R5: numbers beyond each table
        tag = "R5";
        step(1'b1, mk_db(NUM_CQ, 0, 0, 1, 0), 0, 0, 0, 0, 1'b0, 0);
        step(1'b1, mk_db(NUM_EQ, 0, 1, 1, 0), 0, 0, 0, 0, 1'b1, 0);
        idle(1'b0, 0);

        // R6 R10 R7 R8: arm a pending queue and wait for its notification
        tag = "R6";
        step(1'b0, '0, 1'b1, 1'b0, 2, 4, 1'b0, 2);
        step(1'b0, '0, 1'b1, 1'b0, 999, 9, 1'b0, 2);
        step(1'b1, mk_db(2, 1, 0, 0, 0), 0, 0, 0, 0, 1'b0, 2);
        tag = "R7";
        for (int i = 0; i < 2 * TOTAL + 4; i++) idle(1'b0, 2);
        chk(!m_armed[0][2], "queue 2 notified (R8)", int'(m_armed[0][2]), 0);

        // random mix
        tag = "R2";
        for (int n = 0; n < 4000; n++) begin
            bit          dv, pv, pe, eq, re, rsel;
            int          qid, pop, rq;
            logic [6:0]  rsv;
            dv   = ($urandom % 2) == 0;
            eq   = ($urandom % 3) == 0;
            qid  = ($urandom % 10 == 0) ? qcount(eq) + int'($urandom % 4)
                                         : int'($urandom % qcount(eq));
            rsv  = ($urandom % 7 == 0) ? 7'(1 << ($urandom % 7)) : 7'd0;
            pop  = ($urandom % 8 == 0) ? int'($urandom % 8192) : int'($urandom % 6);
            pv   = ($urandom % 3) == 0;
            pe   = ($urandom % 3) == 0;
            rsel = ($urandom % 2) == 0;
            rq   = int'($urandom % (NUM_CQ + 2));
            begin
                int pq;
                int pidx;
                pq   = int'($urandom % qcount(pe));
                pidx = m_cidx[pe][pq] + int'($urandom % 4);
                step(dv, mk_db(qid, ($urandom % 3) == 0, eq, pop, rsv), pv, pe, pq, pidx,
                     rsel, rq);
            end
        end

        // R8: quiet tail, nothing armed and pending may remain
        tag = "R8";
        for (int i = 0; i < 2 * TOTAL + 6; i++) idle(1'b0, 0);
        for (int t = 0; t < 2; t++)
            for (int q = 0; q < qcount(t[0]); q++)
                chk(!(m_armed[t][q] && m_pidx[t][q] != m_cidx[t][q]),
                    "armed pending queue left unserved", q, -1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule